// File: doc/BRIEF.md
# Two-Wire Switch Control and Status Slave

This block is the serial target interface of a small switch-controller chip. A bus master reaches it over a two-wire, open-drain serial bus with a clock line and a data line. Bytes travel most significant bit first, and a START condition frames each transfer. The block holds one 8-bit control register that the master can only write. It answers reads with one 8-bit status byte. The control register drives three decoded select outputs: an output gain bit, a video source code and an audio source code.

A write is one address byte with the direction bit at 0, followed by one control byte. The block ignores any further bytes of that write. A read is one address byte with the direction bit at 1. The block then returns the status byte, and the master answers that byte with a NACK. The status byte carries two things:
- a power-on flag, which drops once the first status read has begun;
- two open/select bit pairs, which encode the three-level state of two sense inputs.

The lines are synchronised into a fast system clock, and the block detects edges, START and STOP in that clock domain. The slave never drives the data line high. `sda_oe` high means the data line is pulled low. The external wired-AND of the bus is the only data path, so the block has no valid/ready stream; every pin is a plain level.

Top module: `swctl_i2c_slave`

## Requirements
- R1: After reset `gain_sel`, `video_sel` and `audio_sel` are all 0, `sda_oe` is 0, and the internal power-on flag is 1.
- R2: The 7-bit target address is binary 100100 followed by `addr_sel`. Write addresses are therefore 90h or 92h and read addresses 91h or 93h. A matching address byte is acknowledged by pulling the data line low during the ninth clock. A non-matching address byte is not acknowledged and changes nothing.
- R3: A write is an address byte with bit 0 equal to 0, then one control byte sent MSB first. The control byte is acknowledged, and it is loaded into the control register at the end of its eighth bit.
- R4: Every byte of a write after the first control byte is left unacknowledged and does not change the control register.
- R5: The outputs decode the control register as follows:
  - `gain_sel` is bit 7;
  - `video_sel` is bits 6..3;
  - `audio_sel` is bits 2..0.
- R6: A read is an address byte with bit 0 equal to 1. The block then shifts out the status byte MSB first. After the ninth clock of that byte (the master's NACK) the data line is released.
- R7: The status byte layout is:
  - bit 7 is the power-on flag;
  - bits 6 and 5 are the first sense input's OPEN and SEL bits;
  - bits 4 and 3 are the second sense input's OPEN and SEL bits;
  - bits 2..0 read as 0.

  A sense level of 2'b00 (low) gives OPEN=0, SEL=1. A level of 2'b01 (mid) gives 0,0. A level of 2'b10 (high) gives 1,0. A level of 2'b11 is treated as mid.
- R8: The first status read after reset returns the power-on flag as 1. Every later read returns 0 until the next reset.
- R9: A START at any point, including a repeated START, restarts address reception. A STOP ends the transaction. A control byte cut off before its eighth bit leaves the control register unchanged.
- R10: `sda_oe` changes only while the synchronised clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low power-on reset |
| scl_in | input | 1 | Serial clock line as seen at the pad |
| sda_in | input | 1 | Serial data line as seen at the pad (wired-AND value) |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| addr_sel | input | 1 | Selects the least significant bit of the 7-bit address |
| s1_level | input | 2 | Three-level state of the first sense input |
| s2_level | input | 2 | Three-level state of the second sense input |
| gain_sel | output | 1 | Output gain select (control bit 7) |
| video_sel | output | 4 | Video source select (control bits 6..3) |
| audio_sel | output | 3 | Audio source select (control bits 2..0) |

## Verification
The assertions assume a single, well-behaved master:
- each clock-line level lasts longer than the synchroniser latency;
- the data line changes while the clock is high only to form a START or a STOP.

Under those conditions the synchronised edges arrive in order, and the slave's drive changes always fall inside a low clock phase. The stimulus keeps every clock phase at three or more system cycles. It moves the master's data only in the middle of a low phase. It raises or drops the line under a high clock only inside its START and STOP tasks.

// File: rtl/swctl_pkg.sv
package swctl_pkg;

  localparam int BYTE_W  = 8;
  localparam int ADDR_W  = 7;
  localparam int VIDEO_W = 4;
  localparam int AUDIO_W = 3;

  localparam logic [1:0] LVL_LOW  = 2'b00;
  localparam logic [1:0] LVL_MID  = 2'b01;
  localparam logic [1:0] LVL_HIGH = 2'b10;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_A,
    ST_WDATA,
    ST_ACK_W,
    ST_SKIP,
    ST_RDATA,
    ST_RACK
  } link_state_t;

  // Returns {open, sel} for a three-level sense input
  function automatic logic [1:0] sense_pair(input logic [1:0] lvl);
    logic [1:0] r;
    case (lvl)
      LVL_LOW:  r = 2'b01;
      LVL_MID:  r = 2'b00;
      LVL_HIGH: r = 2'b10;
      default:  r = 2'b00;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/swctl_line_sync.sv
module swctl_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  localparam int NLINES = 2;

  logic [NLINES-1:0] raw;
  logic [NLINES-1:0] synced;
  logic [NLINES-1:0] prev_q;

  assign raw = {sda_in, scl_in};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '1;
      else        chain_q <= {chain_q[STAGES-2:0], raw[g]};
    end
    assign synced[g] = chain_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '1;
    else        prev_q <= synced;
  end

  assign scl_s     = synced[0];
  assign sda_s     = synced[1];
  assign scl_rise  = synced[0] & ~prev_q[0];
  assign scl_fall  = ~synced[0] & prev_q[0];
  assign start_det = synced[0] & prev_q[0] & prev_q[1] & ~synced[1];
  assign stop_det  = synced[0] & prev_q[0] & ~prev_q[1] & synced[1];

endmodule

// File: rtl/swctl_status_fmt.sv
module swctl_status_fmt
  import swctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_begin,
  input  logic [1:0]        s1_level,
  input  logic [1:0]        s2_level,
  output logic [BYTE_W-1:0] status_byte
);

  logic por_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        por_q <= 1'b1;
    else if (rd_begin) por_q <= 1'b0;
  end

  assign status_byte = {por_q, sense_pair(s1_level), sense_pair(s2_level), 3'b000};

  // R8: the flag only drops in the cycle after a status read was started
  p_por_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(por_q) |-> $past(rd_begin));

  // R8: once cleared, the flag never returns without reset
  p_por_no_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !por_q |=> !por_q);

endmodule

// File: rtl/swctl_link_fsm.sv
module swctl_link_fsm
  import swctl_pkg::*;
#(
  parameter logic [ADDR_W-2:0] ADDR_HI = 6'b100100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_sel,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [BYTE_W-1:0] status_byte,
  output logic              sda_oe,
  output logic              wr_valid,
  output logic [BYTE_W-1:0] wr_data,
  output logic              rd_begin
);

  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W);

  link_state_t       state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] rx_q;
  logic [BYTE_W-1:0] tx_q;
  logic              oe_q;
  logic              wr_valid_q;
  logic [BYTE_W-1:0] wr_data_q;
  logic              rd_begin_q;
  logic [ADDR_W-1:0] my_addr;
  logic              addr_hit;

  assign my_addr  = {ADDR_HI, addr_sel};
  assign addr_hit = (rx_q[BYTE_W-1:1] == my_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      rx_q       <= '0;
      tx_q       <= '0;
      oe_q       <= 1'b0;
      wr_valid_q <= 1'b0;
      wr_data_q  <= '0;
      rd_begin_q <= 1'b0;
    end else begin
      wr_valid_q <= 1'b0;
      rd_begin_q <= 1'b0;
      if (start_det) begin
        state_q <= ST_ADDR;
        cnt_q   <= '0;
        oe_q    <= 1'b0;
      end else if (stop_det) begin
        state_q <= ST_IDLE;
        cnt_q   <= '0;
        oe_q    <= 1'b0;
      end else begin
        case (state_q)
          ST_ADDR: begin
            if (scl_rise) begin
              rx_q  <= {rx_q[BYTE_W-2:0], sda_s};
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall && cnt_q == LAST) begin
              if (addr_hit) begin
                state_q <= ST_ACK_A;
                oe_q    <= 1'b1;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          ST_ACK_A: begin
            if (scl_fall) begin
              cnt_q <= '0;
              if (rx_q[0]) begin
                state_q    <= ST_RDATA;
                tx_q       <= status_byte;
                oe_q       <= ~status_byte[BYTE_W-1];
                rd_begin_q <= 1'b1;
              end else begin
                state_q <= ST_WDATA;
                oe_q    <= 1'b0;
              end
            end
          end
          ST_WDATA: begin
            if (scl_rise) begin
              rx_q  <= {rx_q[BYTE_W-2:0], sda_s};
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall && cnt_q == LAST) begin
              state_q    <= ST_ACK_W;
              oe_q       <= 1'b1;
              wr_valid_q <= 1'b1;
              wr_data_q  <= rx_q;
            end
          end
          ST_ACK_W: begin
            if (scl_fall) begin
              oe_q    <= 1'b0;
              state_q <= ST_SKIP;
            end
          end
          ST_RDATA: begin
            if (scl_rise) begin
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall) begin
              if (cnt_q == LAST) begin
                oe_q    <= 1'b0;
                state_q <= ST_RACK;
              end else begin
                tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
                oe_q <= ~tx_q[BYTE_W-2];
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) state_q <= ST_IDLE;
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe   = oe_q;
  assign wr_valid = wr_valid_q;
  assign wr_data  = wr_data_q;
  assign rd_begin = rd_begin_q;

  // R10: drive changes only in a low clock phase
  p_drive_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(oe_q) |-> !scl_s);

  // R2: address acknowledge only after a matching address byte
  p_ack_on_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ACK_A) |-> addr_hit);

  // R4: later write bytes are never acknowledged
  p_skip_released_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SKIP) |-> !oe_q);

  // R6: line released for the master's answer to the status byte
  p_rack_released_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RACK) |-> !oe_q);

  // R9: a START always restarts the address phase with the line released
  p_start_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (state_q == ST_ADDR) && !oe_q);

endmodule

// File: rtl/swctl_i2c_slave.sv
module swctl_i2c_slave
  import swctl_pkg::*;
#(
  parameter int              SYNC_STAGES = 2,
  parameter logic [ADDR_W-2:0] ADDR_HI   = 6'b100100
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_in,
  input  logic               sda_in,
  output logic               sda_oe,
  input  logic               addr_sel,
  input  logic [1:0]         s1_level,
  input  logic [1:0]         s2_level,
  output logic               gain_sel,
  output logic [VIDEO_W-1:0] video_sel,
  output logic [AUDIO_W-1:0] audio_sel
);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic wr_valid, rd_begin;
  logic [BYTE_W-1:0] wr_data;
  logic [BYTE_W-1:0] status_byte;
  logic [BYTE_W-1:0] ctrl_q;

  swctl_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_in    (scl_in),
    .sda_in    (sda_in),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  swctl_status_fmt u_status (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_begin    (rd_begin),
    .s1_level    (s1_level),
    .s2_level    (s2_level),
    .status_byte (status_byte)
  );

  swctl_link_fsm #(.ADDR_HI(ADDR_HI)) u_link (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr_sel    (addr_sel),
    .scl_s       (scl_s),
    .sda_s       (sda_s),
    .scl_rise    (scl_rise),
    .scl_fall    (scl_fall),
    .start_det   (start_det),
    .stop_det    (stop_det),
    .status_byte (status_byte),
    .sda_oe      (sda_oe),
    .wr_valid    (wr_valid),
    .wr_data     (wr_data),
    .rd_begin    (rd_begin)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ctrl_q <= '0;
    else if (wr_valid) ctrl_q <= wr_data;
  end

  assign gain_sel  = ctrl_q[BYTE_W-1];
  assign video_sel = ctrl_q[BYTE_W-2 -: VIDEO_W];
  assign audio_sel = ctrl_q[AUDIO_W-1:0];

  // R3: the register moves only on a committed control byte
  p_ctrl_on_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl_q) |-> $past(wr_valid));

  // R9: no commit coincides with a STOP being seen
  p_no_commit_at_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !wr_valid);

endmodule

// File: tb/swctl_i2c_slave_bench.sv
module swctl_i2c_slave_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic m_sda = 1'b1;
  logic addr_sel = 1'b0;
  logic [1:0] s1_level = 2'b00;
  logic [1:0] s2_level = 2'b00;
  logic sda_oe, gain_sel;
  logic [3:0] video_sel;
  logic [2:0] audio_sel;
  logic sda_line;

  int n_tests = 0;
  int n_fail  = 0;
  int r10_viol = 0;
  logic oe_prev = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  assign sda_line = m_sda & ~sda_oe;

  swctl_i2c_slave u_swctl_i2c_slave (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_in    (scl_m),
    .sda_in    (sda_line),
    .sda_oe    (sda_oe),
    .addr_sel  (addr_sel),
    .s1_level  (s1_level),
    .s2_level  (s2_level),
    .gain_sel  (gain_sel),
    .video_sel (video_sel),
    .audio_sel (audio_sel)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; scl_m = 1'b1; tick(4);
    m_sda = 1'b0; tick(4);
    scl_m = 1'b0; tick(3);
  endtask

  task automatic bus_rstart();
    tick(3); m_sda = 1'b1; tick(3);
    scl_m = 1'b1; tick(6);
    m_sda = 1'b0; tick(6);
    scl_m = 1'b0; tick(3);
  endtask

  task automatic bus_stop();
    tick(3); m_sda = 1'b0; tick(3);
    scl_m = 1'b1; tick(6);
    m_sda = 1'b1; tick(6);
  endtask

  task automatic send_bit(input logic b, output logic seen);
    tick(3); m_sda = b; tick(3);
    scl_m = 1'b1; tick(3);
    seen = sda_line; tick(3);
    scl_m = 1'b0;
  endtask

  task automatic write_byte(input logic [7:0] v, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) send_bit(v[i], s);
    send_bit(1'b1, s);
    acked = ~s;
  endtask

  task automatic read_byte(output logic [7:0] v);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      send_bit(1'b1, s);
      v[i] = s;
    end
    send_bit(1'b1, s);
  endtask

  function automatic logic [1:0] exp_pair(input logic [1:0] lvl);
    if (lvl == 2'b00) return 2'b01;
    if (lvl == 2'b10) return 2'b10;
    return 2'b00;
  endfunction

  function automatic logic [7:0] exp_status(input logic por, input logic [1:0] a, input logic [1:0] b);
    return {por, exp_pair(a), exp_pair(b), 3'b000};
  endfunction

  function automatic logic [7:0] ctrl_now();
    return {gain_sel, video_sel, audio_sel};
  endfunction

  task automatic do_write(input logic [7:0] v, output logic aa, output logic da);
    bus_start();
    write_byte({6'b100100, addr_sel, 1'b0}, aa);
    write_byte(v, da);
    bus_stop();
  endtask

  task automatic do_read(output logic aa, output logic [7:0] v);
    bus_start();
    write_byte({6'b100100, addr_sel, 1'b1}, aa);
    read_byte(v);
    bus_stop();
  endtask

  // R10 monitor: drive changes only while the clock line is low
  always @(posedge clk) begin
    #5;
    if (rst_n && sda_oe !== oe_prev && scl_m) r10_viol++;
    oe_prev = sda_oe;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic aa, da;
    logic [7:0] v;
    tick(5);
    rst_n = 1'b1;
    tick(5);
    // R1 reset state
    chk("R1 ctrl", {24'd0, ctrl_now()}, 32'h0);
    chk("R1 sda_oe", {31'd0, sda_oe}, 32'h0);

    // R8 first read has flag set, then clears; R7 layout
    s1_level = 2'b00; s2_level = 2'b10;
    do_read(aa, v);
    chk("R2 read ack", {31'd0, aa}, 32'h1);
    chk("R8 first read", {24'd0, v}, {24'd0, exp_status(1'b1, 2'b00, 2'b10)});
    chk("R6 released", {31'd0, sda_oe}, 32'h0);
    do_read(aa, v);
    chk("R8 second read", {24'd0, v}, {24'd0, exp_status(1'b0, 2'b00, 2'b10)});

    // R7 sweep over all sense levels
    for (int a = 0; a < 4; a++) begin
      for (int b = 0; b < 4; b++) begin
        s1_level = 2'(a); s2_level = 2'(b);
        do_read(aa, v);
        chk("R7 status", {24'd0, v}, {24'd0, exp_status(1'b0, 2'(a), 2'(b))});
      end
    end

    // R3/R5 sweep over all control values, both address selects
    for (int k = 0; k < 256; k++) begin
      addr_sel = k[0];
      do_write(8'(k), aa, da);
      chk("R3 addr ack", {31'd0, aa}, 32'h1);
      chk("R3 data ack", {31'd0, da}, 32'h1);
      chk("R5 gain", {31'd0, gain_sel}, {31'd0, k[7]});
      chk("R5 video", {28'd0, video_sel}, {28'd0, k[6:3]});
      chk("R5 audio", {29'd0, audio_sel}, {29'd0, k[2:0]});
    end

    // R2 address sweep: ack only on a match, no effect otherwise
    addr_sel = 1'b0;
    do_write(8'hC3, aa, da);
    for (int s = 0; s < 2; s++) begin
      addr_sel = s[0];
      for (int a = 0; a < 128; a++) begin
        bus_start();
        write_byte({7'(a), 1'b0}, aa);
        bus_stop();
        chk("R2 match", {31'd0, aa}, {31'd0, (a == (8'h48 | s))});
      end
    end
    chk("R2 no effect", {24'd0, ctrl_now()}, 32'hC3);

    // R2 wrong select bit on a write: not acked, register unchanged
    addr_sel = 1'b1;
    bus_start();
    write_byte(8'h90, aa);
    write_byte(8'h11, da);
    bus_stop();
    chk("R2 wrong sel ack", {31'd0, aa}, 32'h0);
    chk("R2 wrong sel ctrl", {24'd0, ctrl_now()}, 32'hC3);

    // R4 trailing bytes ignored
    addr_sel = 1'b0;
    bus_start();
    write_byte(8'h90, aa);
    write_byte(8'h5A, da);
    write_byte(8'hFF, aa);
    chk("R4 extra nack", {31'd0, aa}, 32'h0);
    write_byte(8'h00, aa);
    bus_stop();
    chk("R4 ctrl kept", {24'd0, ctrl_now()}, 32'h5A);

    // R9 STOP inside a control byte
    bus_start();
    write_byte(8'h90, aa);
    for (int i = 0; i < 4; i++) send_bit(1'b1, da);
    bus_stop();
    chk("R9 cut byte", {24'd0, ctrl_now()}, 32'h5A);

    // R9 repeated START turns a write into a read
    s1_level = 2'b10; s2_level = 2'b01;
    bus_start();
    write_byte(8'h90, aa);
    for (int i = 0; i < 3; i++) send_bit(1'b0, da);
    bus_rstart();
    write_byte(8'h91, aa);
    read_byte(v);
    bus_stop();
    chk("R9 rstart ack", {31'd0, aa}, 32'h1);
    chk("R9 rstart status", {24'd0, v}, {24'd0, exp_status(1'b0, 2'b10, 2'b01)});
    chk("R9 rstart ctrl", {24'd0, ctrl_now()}, 32'h5A);

    // R1/R8 second reset restores flag and clears register
    rst_n = 1'b0; tick(3); rst_n = 1'b1; tick(3);
    chk("R1 reset ctrl", {24'd0, ctrl_now()}, 32'h0);
    do_read(aa, v);
    chk("R8 after reset", {31'd0, v[7]}, 32'h1);

    chk("R10 drive timing", r10_viol, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule